// File: doc/BRIEF.md
# Cache Way Shrink Controller

This block reduces the number of active ways of a set-associative cache each time the core drops into a deep sleep state. It does so only when the core has not stayed in its normal running state for long, and only when an externally measured ratio is under a configured threshold. When a shrink is granted, the block asks the cache to flush the chosen ways. It asks for one way at a time, starting with the highest enabled index. It disables each way once the cache reports that way's flush complete.

A residency timer counts cycles spent in the normal state. Once it reaches a programmable limit, it expires. An expired timer suppresses shrinking and brings every way back. Each accepted sleep entry clears the timer. The first entry after expiry therefore re-arms it, and entries that follow closely can each remove more ways.

The enabled ways always form a contiguous run starting at way 0. Way 0 can never be removed.

Top module: `way_shrink_ctrl`

## Requirements
- R1: After reset, all NUM_WAYS ways are enabled, no flush request is raised, `busy_o` is low, and the residency timer is cleared and not expired.
- R2: A sleep pulse is accepted when `busy_o` is low. It starts a shrink only if the timer has not expired and the ratio condition holds. The shrink removes min(`step_ways_i`, enabled−1) ways. If that amount is zero, for example because the step is 0, nothing starts and `busy_o` stays low.
- R3: The ratio condition holds when `thresh_i` is 0, or when `ratio_i` < `thresh_i`. When `ratio_i` ≥ a non-zero `thresh_i`, an accepted pulse removes no way.
- R4: The timer adds one in every cycle where `in_normal_i` is high and the timer has not expired. It expires at the clock edge where its new count is ≥ `res_limit_i`, so a limit of 0 expires on the first normal cycle. An accepted pulse arriving while the timer is expired starts no shrink.
- R5: While the timer is expired and `busy_o` is low, the next edge re-enables all ways (`way_en_o` all ones).
- R6: Every accepted pulse clears the timer and its expired state. The next accepted pulse can therefore shrink again.
- R7: While busy, `flush_req_o` is one-hot at the highest enabled way; otherwise it is zero. `busy_o` rises in the cycle after the accepted pulse. It falls in the cycle after the acknowledge of the last way in the step.
- R8: A way's bit in `way_en_o` clears in the cycle after a `flush_done_i` that arrives while busy. `flush_done_i` has no effect while not busy.
- R9: Bit 0 of `way_en_o` is always set, because a step that would go past one enabled way is clipped.
- R10: A sleep pulse that arrives while `busy_o` is high is ignored. It neither changes the step in progress nor clears the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_entry_i | input | 1 | One-cycle pulse on deep-sleep entry |
| in_normal_i | input | 1 | High while the core is in its normal running state |
| step_ways_i | input | $clog2(NUM_WAYS+1) | Ways to remove per granted shrink |
| thresh_i | input | RATIO_W | Shrink threshold; 0 disables the ratio test |
| ratio_i | input | RATIO_W | Measured ratio |
| res_limit_i | input | CNT_W | Residency timer limit in cycles |
| flush_done_i | input | 1 | Cache reports the requested way flushed |
| way_en_o | output | NUM_WAYS | Way-enable mask, bit i for way i |
| flush_req_o | output | NUM_WAYS | Per-way flush request, one-hot while busy |
| busy_o | output | 1 | Shrink sequence in progress |

## Verification
The assertions check four rules on every cycle. The flush request is one-hot at the top enabled way and appears only while busy. Way 0 never drops. Enabled ways disappear only after an acknowledge received while busy. The mask grows only by a full restore. They also check that a sleep pulse during a sequence leaves the busy flag and the mask unchanged. The bench scenarios are needed for the rules that depend on timing history or configuration. These are the exact residency count at which expiry happens, the zero limit, the zero threshold, the clipped and zero steps, the re-arming of the timer by the first entry after expiry, and the choice of how many ways a step removes.

// File: rtl/way_shrink_ctrl.sv
module way_shrink_ctrl #(
  parameter int NUM_WAYS = 8,
  parameter int CNT_W    = 16,
  parameter int RATIO_W  = 8,
  localparam int EW      = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_entry_i,
  input  logic                in_normal_i,
  input  logic [EW-1:0]       step_ways_i,
  input  logic [RATIO_W-1:0]  thresh_i,
  input  logic [RATIO_W-1:0]  ratio_i,
  input  logic [CNT_W-1:0]    res_limit_i,
  input  logic                flush_done_i,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic [NUM_WAYS-1:0] flush_req_o,
  output logic                busy_o
);

  logic [EW-1:0]    en_q, rem_q, n_take;
  logic             busy_q, exp_q;
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W:0]   tmr_nxt;

  wire accept = sleep_entry_i && !busy_q;
  wire thr_ok = (thresh_i == '0) || (ratio_i < thresh_i);
  assign n_take  = (step_ways_i < en_q) ? step_ways_i : en_q - 1'b1;
  wire start  = accept && !exp_q && thr_ok && (n_take != '0);
  assign tmr_nxt = {1'b0, tmr_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= EW'(NUM_WAYS);
      rem_q  <= '0;
      busy_q <= 1'b0;
      exp_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      if (busy_q) begin
        if (flush_done_i) begin
          en_q  <= en_q - 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == EW'(1)) busy_q <= 1'b0;
        end
      end else if (exp_q) begin
        en_q <= EW'(NUM_WAYS);
      end else if (start) begin
        busy_q <= 1'b1;
        rem_q  <= n_take;
      end

      if (accept) begin
        tmr_q <= '0;
        exp_q <= 1'b0;
      end else if (in_normal_i && !exp_q) begin
        tmr_q <= tmr_nxt[CNT_W-1:0];
        if (tmr_nxt >= {1'b0, res_limit_i}) exp_q <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    assign way_en_o[i]    = EW'(i) < en_q;
    assign flush_req_o[i] = busy_q && (EW'(i) + 1'b1 == en_q);
  end

  assign busy_o = busy_q;

endmodule

module way_shrink_ctrl_chk #(
  parameter int NUM_WAYS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_entry_i,
  input logic                flush_done_i,
  input logic [NUM_WAYS-1:0] way_en_o,
  input logic [NUM_WAYS-1:0] flush_req_o,
  input logic                busy_o
);

  p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(flush_req_o) == 1));

  p_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (flush_req_o == '0));

  p_req_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (NUM_WAYS'(flush_req_o << 1) == NUM_WAYS'(way_en_o + 1'b1)));

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    way_en_o[0]);

  p_clear_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(way_en_o) < $countones($past(way_en_o))) |-> $past(flush_done_i && busy_o));

  p_grow_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(way_en_o) > $countones($past(way_en_o))) |-> (&way_en_o));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sleep_entry_i && !flush_done_i) |=> (busy_o && $stable(way_en_o)));

endmodule

bind way_shrink_ctrl way_shrink_ctrl_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_entry_i(sleep_entry_i), .flush_done_i(flush_done_i),
  .way_en_o(way_en_o), .flush_req_o(flush_req_o), .busy_o(busy_o)
);

// File: tb/way_shrink_ctrl_bench.sv
module way_shrink_ctrl_bench;
  localparam int N  = 8;
  localparam int EW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0, normal = 1'b0, ack = 1'b0;
  logic [EW-1:0] step = '0;
  logic [7:0] thr = '0, ratio = '0;
  logic [15:0] lim = 16'd20;
  logic [N-1:0] way_en, req;
  logic busy;

  int n_chk = 0, n_fail = 0;
  int m_en = N, m_rem = 0, m_t = 0;
  bit m_busy = 0, m_exp = 0;

  always #4 clk = ~clk;

  way_shrink_ctrl #(.NUM_WAYS(N)) u_way_shrink_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_entry_i(sleep), .in_normal_i(normal),
    .step_ways_i(step), .thresh_i(thr), .ratio_i(ratio), .res_limit_i(lim),
    .flush_done_i(ack), .way_en_o(way_en), .flush_req_o(req), .busy_o(busy));

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = N; m_rem = 0; m_busy = 0; m_exp = 0; m_t = 0;
    end else begin
      bit acc, o_busy, o_exp, thr_ok;
      int take;
      acc = sleep && !m_busy;
      o_busy = m_busy; o_exp = m_exp;
      thr_ok = (thr == 0) || (ratio < thr);
      take = (int'(step) < m_en) ? int'(step) : m_en - 1;
      if (o_busy) begin
        if (ack) begin m_en--; m_rem--; if (m_rem == 0) m_busy = 0; end
      end else if (o_exp) m_en = N;
      else if (acc && thr_ok && take > 0) begin m_busy = 1; m_rem = take; end
      if (acc) begin m_t = 0; m_exp = 0; end
      else if (normal && !o_exp) begin m_t++; if (m_t >= int'(lim)) m_exp = 1; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R8", int'(way_en), (1 << m_en) - 1);
    chk("R7", int'(req), m_busy ? (1 << (m_en - 1)) : 0);
    chk("R7", int'(busy), int'(m_busy));
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep = 1'b1; tick(); sleep = 1'b0;
  endtask

  task automatic drain(int d);
    while (busy) begin tick(d); ack = 1'b1; tick(); ack = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick();
    chk("R1", int'(way_en), 8'hFF); chk("R1", int'(req), 0); chk("R1", int'(busy), 0);

    step = 3; pulse_sleep();
    chk("R2", int'(busy), 1); chk("R7", int'(req), 8'h80);
    drain(2);
    chk("R2", int'(way_en), 8'h1F);

    step = 2; pulse_sleep(); tick();
    pulse_sleep();
    chk("R10", int'(busy), 1);
    drain(1);
    chk("R10", int'(way_en), 8'h07);

    thr = 10; ratio = 10; step = 1; pulse_sleep();
    chk("R3", int'(busy), 0); chk("R3", int'(way_en), 8'h07);
    ratio = 9; pulse_sleep(); drain(0);
    chk("R3", int'(way_en), 8'h03);

    thr = 0; ratio = 200; step = 7; pulse_sleep(); drain(1);
    chk("R9", int'(way_en), 8'h01);
    pulse_sleep();
    chk("R9", int'(busy), 0); chk("R9", int'(way_en), 8'h01);

    ack = 1'b1; tick(); ack = 1'b0; tick();
    chk("R8", int'(way_en), 8'h01);

    normal = 1'b1; tick(19);
    chk("R4", int'(way_en), 8'h01);
    tick(3);
    chk("R5", int'(way_en), 8'hFF);
    step = 2; pulse_sleep(); normal = 1'b0; tick();
    chk("R4", int'(busy), 0); chk("R4", int'(way_en), 8'hFF);
    pulse_sleep(); drain(1);
    chk("R6", int'(way_en), 8'h3F);

    step = 0; pulse_sleep();
    chk("R2", int'(busy), 0); chk("R2", int'(way_en), 8'h3F);

    normal = 1'b1; tick(10); step = 1; pulse_sleep(); normal = 1'b0; drain(1);
    chk("R4", int'(way_en), 8'h1F);

    lim = 0; normal = 1'b1; tick(); normal = 1'b0; tick();
    chk("R4", int'(way_en), 8'hFF);
    pulse_sleep(); tick();
    chk("R6", int'(busy), 0);
    step = 4; pulse_sleep(); drain(3);
    chk("R6", int'(way_en), 8'h0F);

    tick(2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule